// File: doc/BRIEF.md
# Configuration Frame CRC Checker

This block sits on the frame section of an FPGA configuration byte stream. The stream arrives one byte per cycle while `valid_i` is high. A one-cycle `start_i` pulse arms the block. With that pulse it takes the number of frames to expect, a CRC enable and a 16-bit CRC seed. The seed is the running CRC that an upstream command parser has already built over the command bytes that belong to the first frame's coverage.

Each frame has three parts in this order:
- `FRAME_BYTES` data bytes;
- two CRC bytes;
- `PAD_BYTES` padding bytes that must all be 0xFF.

The block passes each data byte out with a strobe and checks each frame's CRC and padding. It pulses once when a frame is complete. After the last frame comes a closing trailer of `TRAIL_BYTES` 0xFF bytes followed by a CRC. That CRC covers the last frame's padding together with the trailer bytes, and the block checks it too. Its error flags stay set until reset, so a downstream loader can look at them once the section-done flag rises.

Top module: `cfg_frame_crc_chk`

## Requirements
- R1: After reset, `data_vld_o`, `frame_done_o`, `crc_err_o`, `frame_err_o` and `section_done_o` are all 0.
- R2: Every frame data byte taken with `valid_i` high appears on `data_o` with `data_vld_o` high exactly one cycle later. CRC, padding and trailer bytes never raise `data_vld_o`. Cycles with `valid_i` low are skipped and do not advance the framing.
- R3: The frame CRC is a reflected CRC-16 with polynomial 0xA001, processed LSB first within each byte, with no final XOR. The received CRC arrives low byte first, then high byte. A mismatch sets `crc_err_o` one cycle after the high byte.
- R4: The first frame's CRC starts from `seed_i`, captured at `start_i`. Every later frame's CRC starts from 0x0000.
- R5: If `crc_en_i` was 0 at `start_i`, no CRC mismatch in that section, frame or trailer, sets `crc_err_o`.
- R6: Each byte in a frame's padding or in the trailer's 0xFF run that is not 0xFF sets `frame_err_o` one cycle after that byte.
- R7: `frame_done_o` is a one-cycle pulse, one cycle after the last padding byte of each frame.
- R8: After the last frame come `TRAIL_BYTES` 0xFF bytes and two CRC bytes, low byte first. Those CRC bytes must equal the CRC, started from 0x0000, over the last frame's `PAD_BYTES` padding bytes followed by the trailer bytes. A mismatch sets `crc_err_o`.
- R9: `section_done_o` rises one cycle after the trailer's high CRC byte and holds until the next `start_i`. While it is high, bytes produce no strobes and no frame pulses.
- R10: `crc_err_o` and `frame_err_o` are sticky: only reset clears them, and `start_i` does not.
- R11: `frames_i`, captured at `start_i`, gives the number of frames. A section with N frames gives exactly N `frame_done_o` pulses before the trailer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms a new section, captures frames_i, crc_en_i, seed_i |
| frames_i | input | CNT_W | Number of frames in the section |
| crc_en_i | input | 1 | Enables CRC comparison for the section |
| seed_i | input | 16 | Starting CRC value for the first frame |
| valid_i | input | 1 | byte_i carries a stream byte this cycle |
| byte_i | input | 8 | Stream byte |
| data_vld_o | output | 1 | data_o holds a frame data byte |
| data_o | output | 8 | Frame data byte |
| frame_done_o | output | 1 | One-cycle pulse per completed frame |
| crc_err_o | output | 1 | Sticky CRC mismatch flag |
| frame_err_o | output | 1 | Sticky padding error flag |
| section_done_o | output | 1 | Trailer checked, section finished |

## Verification
A padding error and the end of a frame can be reported in the same cycle. This happens when the corrupted byte is the final padding byte of a frame: `frame_err_o` must rise in exactly the cycle in which `frame_done_o` pulses. The bench sets this up by replacing the last padding byte of the last frame with 0x7F. A negedge monitor then records whether the first cycle with `frame_err_o` high also carries the `frame_done_o` pulse. The same bad byte also enters the trailer CRC. The bench folds that byte into its own trailer CRC, so no CRC error may appear alongside the padding error.

// File: rtl/cfg_crc_pkg.sv
package cfg_crc_pkg;
  localparam logic [15:0] CRC_POLY = 16'hA001;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DATA,
    PH_CRC,
    PH_PAD,
    PH_TRAIL,
    PH_TCRC,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/crc16_step.sv
module crc16_step
  import cfg_crc_pkg::*;
(
  input  logic [15:0] crc_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  logic [15:0] st [0:8];

  assign st[0] = crc_i ^ {8'h00, byte_i};

  for (genvar k = 0; k < 8; k++) begin : g_bit
    assign st[k+1] = st[k][0] ? ((st[k] >> 1) ^ CRC_POLY) : (st[k] >> 1);
  end

  assign crc_o = st[8];
endmodule

// File: rtl/cfg_crc_seq.sv
module cfg_crc_seq
  import cfg_crc_pkg::*;
#(
  parameter int FRAME_BYTES = 8,
  parameter int PAD_BYTES   = 6,
  parameter int TRAIL_BYTES = 18,
  parameter int CNT_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] frames_i,
  input  logic             step_i,
  output phase_e           phase_o,
  output logic             phase_end_o,
  output logic             last_frame_o
);
  localparam int MAX_AB = (FRAME_BYTES > PAD_BYTES) ? FRAME_BYTES : PAD_BYTES;
  localparam int MAX_B  = (MAX_AB > TRAIL_BYTES) ? MAX_AB : TRAIL_BYTES;
  localparam int BW     = $clog2(MAX_B + 1);

  phase_e           phase_q;
  logic [BW-1:0]    cnt_q;
  logic [BW-1:0]    last_idx;
  logic [CNT_W-1:0] left_q;

  always_comb begin
    case (phase_q)
      PH_DATA:  last_idx = BW'(FRAME_BYTES - 1);
      PH_PAD:   last_idx = BW'(PAD_BYTES - 1);
      PH_TRAIL: last_idx = BW'(TRAIL_BYTES - 1);
      default:  last_idx = BW'(1);
    endcase
  end

  assign phase_end_o  = (cnt_q == last_idx);
  assign last_frame_o = (left_q == CNT_W'(1));
  assign phase_o      = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
    end else if (start_i) begin
      phase_q <= (frames_i == '0) ? PH_TRAIL : PH_DATA;
      cnt_q   <= '0;
      left_q  <= frames_i;
    end else if (step_i) begin
      if (!phase_end_o) begin
        cnt_q <= cnt_q + BW'(1);
      end else begin
        cnt_q <= '0;
        case (phase_q)
          PH_DATA:  phase_q <= PH_CRC;
          PH_CRC:   phase_q <= PH_PAD;
          PH_PAD: begin
            phase_q <= last_frame_o ? PH_TRAIL : PH_DATA;
            left_q  <= left_q - CNT_W'(1);
          end
          PH_TRAIL: phase_q <= PH_TCRC;
          PH_TCRC:  phase_q <= PH_DONE;
          default:  phase_q <= phase_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_frame_crc_chk.sv
module cfg_frame_crc_chk
  import cfg_crc_pkg::*;
#(
  parameter int FRAME_BYTES = 8,
  parameter int PAD_BYTES   = 6,
  parameter int TRAIL_BYTES = 18,
  parameter int CNT_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] frames_i,
  input  logic             crc_en_i,
  input  logic [15:0]      seed_i,
  input  logic             valid_i,
  input  logic [7:0]       byte_i,
  output logic             data_vld_o,
  output logic [7:0]       data_o,
  output logic             frame_done_o,
  output logic             crc_err_o,
  output logic             frame_err_o,
  output logic             section_done_o
);
  phase_e      phase;
  logic        phase_end;
  logic        last_frame;
  logic        step;
  logic [15:0] crc_q, crc_nxt;
  logic [7:0]  lo_q;
  logic        en_q;
  logic        crc_bad;

  assign step    = valid_i && !start_i && (phase != PH_IDLE) && (phase != PH_DONE);
  assign crc_bad = en_q && ({byte_i, lo_q} != crc_q);

  cfg_crc_seq #(
    .FRAME_BYTES(FRAME_BYTES),
    .PAD_BYTES  (PAD_BYTES),
    .TRAIL_BYTES(TRAIL_BYTES),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .frames_i    (frames_i),
    .step_i      (step),
    .phase_o     (phase),
    .phase_end_o (phase_end),
    .last_frame_o(last_frame)
  );

  crc16_step u_crc (
    .crc_i (crc_q),
    .byte_i(byte_i),
    .crc_o (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q          <= '0;
      lo_q           <= '0;
      en_q           <= 1'b0;
      data_vld_o     <= 1'b0;
      data_o         <= '0;
      frame_done_o   <= 1'b0;
      crc_err_o      <= 1'b0;
      frame_err_o    <= 1'b0;
      section_done_o <= 1'b0;
    end else begin
      data_vld_o   <= 1'b0;
      frame_done_o <= 1'b0;
      if (start_i) begin
        crc_q          <= seed_i;
        en_q           <= crc_en_i;
        section_done_o <= 1'b0;
      end else if (step) begin
        case (phase)
          PH_DATA: begin
            crc_q      <= crc_nxt;
            data_vld_o <= 1'b1;
            data_o     <= byte_i;
          end
          PH_CRC, PH_TCRC: begin
            if (!phase_end) begin
              lo_q <= byte_i;
            end else begin
              if (crc_bad) crc_err_o <= 1'b1;
              crc_q <= '0;
              if (phase == PH_TCRC) section_done_o <= 1'b1;
            end
          end
          PH_PAD: begin
            if (byte_i != 8'hFF) frame_err_o <= 1'b1;
            // padding of the last frame opens the trailer CRC
            crc_q <= (phase_end && !last_frame) ? 16'h0000 : crc_nxt;
            if (phase_end) frame_done_o <= 1'b1;
          end
          PH_TRAIL: begin
            if (byte_i != 8'hFF) frame_err_o <= 1'b1;
            crc_q <= crc_nxt;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_frame_crc_sva.sv
module cfg_frame_crc_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       valid_i,
  input logic       data_vld_o,
  input logic       frame_done_o,
  input logic       crc_err_o,
  input logic       frame_err_o,
  input logic       section_done_o
);
  assert_strobe_needs_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> $past(valid_i));

  assert_no_strobe_on_pad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_vld_o && frame_done_o));

  assert_frame_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  assert_frame_done_needs_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(valid_i));

  assert_crc_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |=> crc_err_o);

  assert_frame_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o);

  assert_done_rise_on_byte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(section_done_o) |-> $past(valid_i));

  assert_done_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(section_done_o) |-> $past(start_i));

  assert_quiet_when_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (section_done_o && !start_i) |=> !data_vld_o && !frame_done_o);
endmodule

bind cfg_frame_crc_chk cfg_frame_crc_sva u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .valid_i       (valid_i),
  .data_vld_o    (data_vld_o),
  .frame_done_o  (frame_done_o),
  .crc_err_o     (crc_err_o),
  .frame_err_o   (frame_err_o),
  .section_done_o(section_done_o)
);

// File: tb/tb_cfg_frame_crc_chk.sv
module tb_cfg_frame_crc_chk;
  localparam int FB = 8;
  localparam int PB = 6;
  localparam int TB = 18;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] frames_i = '0;
  logic          crc_en_i = 1'b0;
  logic [15:0]   seed_i = '0;
  logic          valid_i = 1'b0;
  logic [7:0]    byte_i = '0;
  logic          data_vld_o, frame_done_o, crc_err_o, frame_err_o, section_done_o;
  logic [7:0]    data_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] cap [0:255];
  logic [7:0] exp_d [0:255];
  int ncap = 0, nexp = 0, nfd = 0;
  bit same_cyc = 0, ferr_prev = 0;

  always #5 clk_i = ~clk_i;

  cfg_frame_crc_chk #(
    .FRAME_BYTES(FB), .PAD_BYTES(PB), .TRAIL_BYTES(TB), .CNT_W(CW)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .frames_i(frames_i),
    .crc_en_i(crc_en_i), .seed_i(seed_i), .valid_i(valid_i), .byte_i(byte_i),
    .data_vld_o(data_vld_o), .data_o(data_o), .frame_done_o(frame_done_o),
    .crc_err_o(crc_err_o), .frame_err_o(frame_err_o), .section_done_o(section_done_o)
  );

  always @(negedge clk_i) begin
    if (data_vld_o && ncap < 256) begin
      cap[ncap] = data_o;
      ncap++;
    end
    if (frame_done_o) nfd++;
    if (frame_done_o && frame_err_o && !ferr_prev) same_cyc = 1;
    ferr_prev = frame_err_o;
  end

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; valid_i = 1'b0; start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    ferr_prev = 0;
  endtask

  task automatic send(input logic [7:0] b);
    valid_i = 1'b1; byte_i = b;
    @(negedge clk_i);
  endtask

  task automatic idle_cyc();
    valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic pulse_start(input int nf, input logic en, input logic [15:0] s);
    start_i = 1'b1; frames_i = CW'(nf); crc_en_i = en; seed_i = s;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic run_section(input int nf, input logic en, input logic [15:0] dut_seed,
                             input logic [15:0] ref_seed, input int bad_crc_f,
                             input int bad_pad_f, input bit bad_tcrc, input bit gaps);
    logic [15:0] c, t;
    logic [7:0]  b;
    ncap = 0; nfd = 0; nexp = 0; same_cyc = 0;
    t = '0;
    pulse_start(nf, en, dut_seed);
    for (int f = 0; f < nf; f++) begin
      c = (f == 0) ? ref_seed : 16'h0000;
      for (int i = 0; i < FB; i++) begin
        b = 8'(f * 37 + i * 11 + 5);
        exp_d[nexp] = b; nexp++;
        c = crc_upd(c, b);
        send(b);
        if (gaps && (i % 3 == 1)) idle_cyc();
      end
      send(c[7:0] ^ ((bad_crc_f == f) ? 8'h01 : 8'h00));
      send(c[15:8]);
      t = '0;
      for (int p = 0; p < PB; p++) begin
        b = (bad_pad_f == f && p == PB - 1) ? 8'h7F : 8'hFF;
        t = crc_upd(t, b);
        send(b);
      end
    end
    for (int k = 0; k < TB; k++) begin
      t = crc_upd(t, 8'hFF);
      send(8'hFF);
      if (gaps && k == 4) idle_cyc();
    end
    send(t[7:0] ^ (bad_tcrc ? 8'h10 : 8'h00));
    send(t[15:8]);
    valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic check_data(input string req);
    int mism = 0;
    for (int i = 0; i < nexp; i++) if (cap[i] !== exp_d[i]) mism++;
    chk({req, " strobe count"}, ncap, nexp);
    chk({req, " data mismatches"}, mism, 0);
  endtask

  task automatic t_reset();
    chk("R1 data_vld", int'(data_vld_o), 0);
    chk("R1 frame_done", int'(frame_done_o), 0);
    chk("R1 crc_err", int'(crc_err_o), 0);
    chk("R1 frame_err", int'(frame_err_o), 0);
    chk("R1 section_done", int'(section_done_o), 0);
  endtask

  task automatic t_basic();
    logic [15:0] s;
    s = crc_upd(crc_upd(crc_upd(crc_upd(16'h0, 8'h3B), 8'h80), 8'h00), 8'h03);
    do_reset();
    run_section(3, 1'b1, s, s, -1, -1, 1'b0, 1'b1);
    check_data("R2");
    chk("R7 R11 frame pulses", nfd, 3);
    chk("R3 R4 clean crc", int'(crc_err_o), 0);
    chk("R6 clean padding", int'(frame_err_o), 0);
    chk("R8 R9 section done", int'(section_done_o), 1);
  endtask

  task automatic t_after_done();
    ncap = 0; nfd = 0;
    for (int i = 0; i < 4; i++) send(8'(8'hA0 + i));
    valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R9 no strobe after done", ncap, 0);
    chk("R9 no pulse after done", nfd, 0);
    chk("R9 done holds", int'(section_done_o), 1);
    pulse_start(1, 1'b1, 16'h0);
    chk("R9 start clears done", int'(section_done_o), 0);
  endtask

  task automatic t_seed();
    do_reset();
    run_section(2, 1'b1, 16'h1234, 16'h1234, -1, -1, 1'b0, 1'b0);
    chk("R4 seeded first frame ok", int'(crc_err_o), 0);
    do_reset();
    run_section(2, 1'b1, 16'h1234, 16'h4321, -1, -1, 1'b0, 1'b0);
    chk("R4 wrong seed detected", int'(crc_err_o), 1);
  endtask

  task automatic t_bad_crc();
    do_reset();
    run_section(3, 1'b1, 16'h0, 16'h0, 1, -1, 1'b0, 1'b0);
    chk("R3 frame crc mismatch", int'(crc_err_o), 1);
    chk("R3 no padding error", int'(frame_err_o), 0);
    run_section(2, 1'b1, 16'h0, 16'h0, -1, -1, 1'b0, 1'b0);
    chk("R10 crc_err survives start", int'(crc_err_o), 1);
    chk("R10 next section completes", int'(section_done_o), 1);
  endtask

  task automatic t_crc_off();
    do_reset();
    run_section(2, 1'b0, 16'h0, 16'h0, 0, -1, 1'b1, 1'b0);
    chk("R5 crc disabled", int'(crc_err_o), 0);
    chk("R5 section done", int'(section_done_o), 1);
    check_data("R5 R2");
  endtask

  task automatic t_bad_pad();
    do_reset();
    run_section(2, 1'b1, 16'h0, 16'h0, -1, 1, 1'b0, 1'b0);
    chk("R6 padding error", int'(frame_err_o), 1);
    chk("R7 error with frame pulse same cycle", int'(same_cyc), 1);
    chk("R11 pulses", nfd, 2);
    chk("R8 trailer crc includes bad pad", int'(crc_err_o), 0);
    run_section(1, 1'b1, 16'h0, 16'h0, -1, -1, 1'b0, 1'b0);
    chk("R10 frame_err survives start", int'(frame_err_o), 1);
  endtask

  task automatic t_bad_tcrc();
    do_reset();
    run_section(1, 1'b1, 16'h0, 16'h0, -1, -1, 1'b1, 1'b0);
    chk("R8 trailer crc mismatch", int'(crc_err_o), 1);
    chk("R8 no padding error", int'(frame_err_o), 0);
    chk("R11 single frame", nfd, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_after_done();
    t_seed();
    t_bad_crc();
    t_crc_off();
    t_bad_pad();
    t_bad_tcrc();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule